// File: doc/BRIEF.md
# Converter Parallel Bus Register Interface

This block is the device side of a parallel host bus for a sampling converter. The host drives active-low chip select, read and write strobes that are not related to the block clock. The block brings them into the clock domain, takes an 8-bit configuration byte on the write edge chosen by a strap pin, and returns the 13-bit signed conversion result on a data bus with per-bit output enables. The result comes out either as one 13-bit word or as two bytes.

The conversion sequencer loads each new result through a load strobe. It reads the configuration fields from `cfg_q`. It sees `rd_done` when the host has finished taking a complete result, which it can use as its trigger to start the next conversion. The single-ended setting turns negative results into zero as they are read out. A result that is split over two byte reads is captured once at the first byte, so both bytes always belong to the same sample.

Top module: `cvt_bus_if`

## Requirements
- R1: After reset, `cfg_q` is 0x10, `rd_oe` and `rd_data` are zero, and a read before any result load returns zero.
- R2: With `wr_edge_sel` high at reset, the configuration takes the `wr_data` value present when the write strobe falls while chip select is low.
- R3: With `wr_edge_sel` low at reset, the configuration takes the `wr_data` value present when the write strobe rises while chip select is low.
- R4: `wr_edge_sel` is sampled only during reset. Changing it afterwards does not change which write edge is used.
- R5: A write strobe given while chip select is high leaves `cfg_q` unchanged.
- R6: With bus-width bit 3 of `cfg_q` set, a read drives all 13 bits (`rd_oe` = 0x1FFF) with the result, where bit 12 is the sign (1 = negative, two's complement).
- R7: With bit 3 clear, only bits 7..0 are enabled (`rd_oe` = 0x00FF). The first read returns result bits 7..0. The second read returns result bits 12..8 in bits 4..0, with the sign copied into bits 7..5.
- R8: With single-ended bit 2 of `cfg_q` set, a result whose bit 12 is 1 reads back as zero. A non-negative result is unchanged.
- R9: `rd_oe` is nonzero only while chip select and read are both low. A read strobe given while chip select is high neither drives the bus nor advances the byte order.
- R10: `rd_done` is a single-cycle pulse after the read strobe rises at the end of a full result: every read in 13-bit mode, only the second byte in 8-bit mode.
- R11: Any accepted configuration write, and any change of bus width, returns the byte order to the low byte.
- R12: In 8-bit mode the result is captured when the low-byte read begins. A result loaded between the two byte reads does not appear in the high byte, and it is returned from the next low-byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; strap sampled while high |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| wr_edge_sel | input | 1 | Strap: 1 = falling write edge, 0 = rising write edge |
| wr_data | input | 8 | Configuration byte from the host bus |
| res_in | input | 13 | New conversion result from the sequencer |
| res_load | input | 1 | Loads `res_in` into the result register |
| rd_data | output | 13 | Read data toward the pads |
| rd_oe | output | 13 | Per-bit pad output enable |
| cfg_q | output | 8 | Configuration: [7:5] command, [4] sync, [3] bus width, [2] single-ended, [1:0] acquisition |
| rd_done | output | 1 | One-cycle pulse when a full result has been read |

## Verification
Every host-strobe change passes through two synchronizer flops and one output register. So `rd_oe`, `rd_data`, `cfg_q` and `rd_done` change on the third rising clock edge after the strobe pin moves. The bench therefore holds each strobe phase for at least three clock cycles, and six where data is sampled. It samples all outputs on the falling clock edge, well after the result is due. `rd_done` is counted over the whole window that follows each read, so a missing pulse or a doubled pulse is seen. Write-edge tests change `wr_data` halfway through the strobe's low phase, so the value that lands in `cfg_q` shows which edge was used.

// File: rtl/cvt_bus_pkg.sv
package cvt_bus_pkg;
  localparam int CFG_W  = 8;
  localparam int RES_W  = 13;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [2:0] cmd;
    logic       sync_in;
    logic       wide;
    logic       clamp_neg;
    logic [1:0] acq;
  } cfg_t;

  localparam cfg_t CFG_RESET = 8'h10;
endpackage

// File: rtl/cvt_strobe_sync.sv
module cvt_strobe_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] pipe [STAGES+1];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= RST_VAL;
    else     pipe[0] <= d_async;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= RST_VAL;
      else     pipe[i] <= pipe[i-1];
    end
  end

  assign q_sync = pipe[STAGES-1];
  assign q_prev = pipe[STAGES];
endmodule

// File: rtl/cvt_cfg_reg.sv
module cvt_cfg_reg
  import cvt_bus_pkg::*;
#(
  parameter int   DW      = CFG_W,
  parameter cfg_t RST_CFG = CFG_RESET
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          edge_strap,
  input  logic          cs_s,
  input  logic          cs_p,
  input  logic          wr_s,
  input  logic          wr_p,
  input  logic [DW-1:0] din_s,
  output cfg_t          cfg,
  output logic          wr_evt
);
  logic strap_q;
  logic fall_hit;
  logic rise_hit;

  always_ff @(posedge clk) begin
    if (rst) strap_q <= edge_strap;
  end

  assign fall_hit = wr_p & ~wr_s & ~cs_s;
  assign rise_hit = ~wr_p & wr_s & ~cs_p;
  assign wr_evt   = strap_q ? fall_hit : rise_hit;

  always_ff @(posedge clk) begin
    if (rst)         cfg <= RST_CFG;
    else if (wr_evt) cfg <= cfg_t'(din_s);
  end
endmodule

// File: rtl/cvt_rd_path.sv
module cvt_rd_path
  import cvt_bus_pkg::*;
#(
  parameter int RW = RES_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          cs_p,
  input  logic          rd_s,
  input  logic          rd_p,
  input  logic          wide,
  input  logic          clamp_neg,
  input  logic          wr_evt,
  input  logic          res_load,
  input  logic [RW-1:0] res_in,
  output logic [RW-1:0] dout,
  output logic [RW-1:0] oe,
  output logic          done
);
  localparam int HI_W  = RW - BW;
  localparam int EXT_W = BW - HI_W;
  localparam int PAD_W = RW - BW;
  localparam logic [RW-1:0] OE_ALL  = '1;
  localparam logic [RW-1:0] OE_BYTE = {{PAD_W{1'b0}}, {BW{1'b1}}};

  logic [RW-1:0] res_q;
  logic [RW-1:0] snap_q;
  logic [RW-1:0] snap_nx;
  logic [RW-1:0] res_view;
  logic [RW-1:0] fmt;
  logic          hi_ptr;
  logic          wide_p;
  logic          rd_begin;
  logic          rd_end;
  logic          active;

  assign rd_begin = rd_p & ~rd_s & ~cs_s;
  assign rd_end   = ~rd_p & rd_s & ~cs_p;
  assign active   = ~cs_s & ~rd_s;

  always_ff @(posedge clk) begin
    if (rst)           res_q <= '0;
    else if (res_load) res_q <= res_in;
  end

  assign res_view = (clamp_neg && res_q[RW-1]) ? '0 : res_q;
  assign snap_nx  = (rd_begin && (wide || !hi_ptr)) ? res_view : snap_q;

  always_ff @(posedge clk) begin
    if (rst) snap_q <= '0;
    else     snap_q <= snap_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_ptr <= 1'b0;
      wide_p <= 1'b0;
    end else begin
      wide_p <= wide;
      if (wr_evt || (wide != wide_p)) hi_ptr <= 1'b0;
      else if (rd_end && !wide)       hi_ptr <= ~hi_ptr;
    end
  end

  always_comb begin
    if (wide)
      fmt = snap_nx;
    else if (!hi_ptr)
      fmt = {{PAD_W{1'b0}}, snap_nx[BW-1:0]};
    else
      fmt = {{PAD_W{1'b0}}, {EXT_W{snap_nx[RW-1]}}, snap_nx[RW-1:BW]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      oe   <= '0;
      done <= 1'b0;
    end else begin
      dout <= active ? fmt : '0;
      oe   <= active ? (wide ? OE_ALL : OE_BYTE) : '0;
      done <= rd_end && (wide || hi_ptr);
    end
  end
endmodule

// File: rtl/cvt_bus_if.sv
module cvt_bus_if
  import cvt_bus_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             wr_edge_sel,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [RES_W-1:0] res_in,
  input  logic             res_load,
  output logic [RES_W-1:0] rd_data,
  output logic [RES_W-1:0] rd_oe,
  output logic [CFG_W-1:0] cfg_q,
  output logic             rd_done
);
  logic [2:0]       strb_s;
  logic [2:0]       strb_p;
  logic [CFG_W-1:0] din_s;
  logic [CFG_W-1:0] din_p;
  cfg_t             cfg;
  logic             wr_evt;

  cvt_strobe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_strb_sync (
    .clk(clk), .rst(rst), .d_async({cs_n, rd_n, wr_n}),
    .q_sync(strb_s), .q_prev(strb_p)
  );

  cvt_strobe_sync #(.W(CFG_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
    .clk(clk), .rst(rst), .d_async(wr_data),
    .q_sync(din_s), .q_prev(din_p)
  );

  cvt_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .edge_strap(wr_edge_sel),
    .cs_s(strb_s[2]), .cs_p(strb_p[2]),
    .wr_s(strb_s[0]), .wr_p(strb_p[0]),
    .din_s(din_p), .cfg(cfg), .wr_evt(wr_evt)
  );

  cvt_rd_path u_rd (
    .clk(clk), .rst(rst),
    .cs_s(strb_s[2]), .cs_p(strb_p[2]),
    .rd_s(strb_s[1]), .rd_p(strb_p[1]),
    .wide(cfg.wide), .clamp_neg(cfg.clamp_neg), .wr_evt(wr_evt),
    .res_load(res_load), .res_in(res_in),
    .dout(rd_data), .oe(rd_oe), .done(rd_done)
  );

  assign cfg_q = cfg;
endmodule

// File: rtl/cvt_bus_if_chk.sv
module cvt_bus_if_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic [7:0]  cfg_q,
  input logic [12:0] rd_data,
  input logic [12:0] rd_oe,
  input logic        rd_done
);
  AST_RESET_CFG: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_q == 8'h10 && rd_oe == 13'h0)); // R1

  AST_NO_CS_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
      |-> $stable(cfg_q)); // R5

  AST_NARROW_UPPER_Z: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[3] |-> (rd_oe[12:8] == 5'h0)); // R7

  AST_CLAMP_NO_NEG: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[2] && cfg_q[3] && rd_oe[12]) |-> !rd_data[12]); // R8

  AST_DONE_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (rd_oe == 13'h0)); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_done |=> !rd_done); // R10

  AST_IDLE_STROBES_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (rd_n && $past(rd_n) && $past(rd_n, 2) && $past(rd_n, 3) && $past(rd_n, 4))
      |-> !rd_done); // R10
endmodule

bind cvt_bus_if cvt_bus_if_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .cfg_q(cfg_q), .rd_data(rd_data), .rd_oe(rd_oe), .rd_done(rd_done)
);

// File: tb/cvt_bus_if_tb.sv
`timescale 1ns/1ps
module cvt_bus_if_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        wr_edge_sel = 1'b1;
  logic [7:0]  wr_data = 8'h0;
  logic [12:0] res_in = 13'h0;
  logic        res_load = 1'b0;
  logic [12:0] rd_data;
  logic [12:0] rd_oe;
  logic [7:0]  cfg_q;
  logic        rd_done;

  int n_chk = 0;
  int n_fail = 0;
  int n_done = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cvt_bus_if u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .wr_edge_sel(wr_edge_sel), .wr_data(wr_data), .res_in(res_in),
    .res_load(res_load), .rd_data(rd_data), .rd_oe(rd_oe),
    .cfg_q(cfg_q), .rd_done(rd_done)
  );

  always @(negedge clk) if (rd_done === 1'b1) n_done++;

  typedef struct packed {
    logic        wide;
    logic        clamp;
    logic [12:0] res;
    logic [12:0] e_lo;
    logic [12:0] e_hi;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 1'b0, 13'h0ABC, 13'h0ABC, 13'h0000},
    '{1'b1, 1'b0, 13'h1F01, 13'h1F01, 13'h0000},
    '{1'b1, 1'b1, 13'h1F01, 13'h0000, 13'h0000},
    '{1'b1, 1'b1, 13'h07FF, 13'h07FF, 13'h0000},
    '{1'b0, 1'b0, 13'h0ABC, 13'h00BC, 13'h000A},
    '{1'b0, 1'b0, 13'h1F01, 13'h0001, 13'h00FF},
    '{1'b0, 1'b1, 13'h1234, 13'h0000, 13'h0000},
    '{1'b0, 1'b0, 13'h1000, 13'h0000, 13'h00F0}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    wr_edge_sel = strap;
    rst = 1'b1;
    wait_n(5);
    rst = 1'b0;
    wait_n(2);
  endtask

  task automatic split_write(input logic [7:0] a, input logic [7:0] b);
    cs_n = 1'b0; wr_data = a; wait_n(3);
    wr_n = 1'b0; wait_n(6);
    wr_data = b; wait_n(6);
    wr_n = 1'b1; wait_n(6);
    cs_n = 1'b1; wr_data = 8'h0; wait_n(3);
  endtask

  task automatic bus_read(output logic [12:0] d, output logic [12:0] oe);
    cs_n = 1'b0; wait_n(3);
    rd_n = 1'b0; wait_n(6);
    d = rd_data; oe = rd_oe;
    rd_n = 1'b1; wait_n(6);
    cs_n = 1'b1; wait_n(3);
  endtask

  task automatic load_res(input logic [12:0] v);
    res_in = v; res_load = 1'b1; wait_n(1);
    res_load = 1'b0; wait_n(1);
  endtask

  function automatic logic [7:0] mk_cfg(input logic wide, input logic clamp);
    return {3'b100, 1'b1, wide, clamp, 2'b00};
  endfunction

  initial begin
    #4ms;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [12:0] d;
    logic [12:0] oe;
    int d0;

    do_reset(1'b1);
    chk("R1 cfg reset", {8'h0, cfg_q}, 16'h0010);
    chk("R1 oe reset", {3'b0, rd_oe}, 16'h0000);
    chk("R1 data reset", {3'b0, rd_data}, 16'h0000);
    bus_read(d, oe);
    chk("R1 first byte after reset", {3'b0, d}, 16'h0000);
    chk("R7 narrow enable mask", {3'b0, oe}, 16'h00FF);
    bus_read(d, oe);
    chk("R1 second byte after reset", {3'b0, d}, 16'h0000);

    split_write(8'h98, 8'h84);
    chk("R2 falling edge data", {8'h0, cfg_q}, 16'h0098);

    for (int i = 0; i < 8; i++) begin
      split_write(mk_cfg(VECS[i].wide, VECS[i].clamp), mk_cfg(VECS[i].wide, VECS[i].clamp));
      load_res(VECS[i].res);
      d0 = n_done;
      bus_read(d, oe);
      if (VECS[i].wide) begin
        chk("R6 R8 wide word", {3'b0, d}, {3'b0, VECS[i].e_lo});
        chk("R6 wide enable", {3'b0, oe}, 16'h1FFF);
        chk("R10 wide done count", 16'(n_done - d0), 16'd1);
      end else begin
        chk("R7 R8 low byte", {3'b0, d}, {3'b0, VECS[i].e_lo});
        chk("R10 no done after low byte", 16'(n_done - d0), 16'd0);
        bus_read(d, oe);
        chk("R7 R8 high byte", {3'b0, d}, {3'b0, VECS[i].e_hi});
        chk("R7 narrow enable", {3'b0, oe}, 16'h00FF);
        chk("R10 narrow done count", 16'(n_done - d0), 16'd1);
      end
    end

    // R5: write strobe with chip select high
    wr_data = 8'h63; wait_n(2);
    wr_n = 1'b0; wait_n(6); wr_n = 1'b1; wait_n(6);
    chk("R5 cfg unchanged", {8'h0, cfg_q}, {8'h0, mk_cfg(1'b0, 1'b0)});

    // R9: read strobe with chip select high
    load_res(13'h0ABC);
    d0 = n_done;
    rd_n = 1'b0; wait_n(6);
    chk("R9 no drive without cs", {3'b0, rd_oe}, 16'h0000);
    rd_n = 1'b1; wait_n(6);
    chk("R9 no done without cs", 16'(n_done - d0), 16'd0);
    bus_read(d, oe);
    chk("R9 byte order not advanced", {3'b0, d}, 16'h00BC);

    // R11: write clears byte order
    split_write(mk_cfg(1'b0, 1'b0), mk_cfg(1'b0, 1'b0));
    bus_read(d, oe);
    chk("R11 low byte after write", {3'b0, d}, 16'h00BC);

    // R11: bus-width change clears byte order
    split_write(mk_cfg(1'b1, 1'b0), mk_cfg(1'b1, 1'b0));
    split_write(mk_cfg(1'b0, 1'b0), mk_cfg(1'b0, 1'b0));
    bus_read(d, oe);
    chk("R11 low byte after width change", {3'b0, d}, 16'h00BC);

    // R12: coherent byte pair
    split_write(mk_cfg(1'b0, 1'b0), mk_cfg(1'b0, 1'b0));
    bus_read(d, oe);
    chk("R12 low byte of first sample", {3'b0, d}, 16'h00BC);
    load_res(13'h1F01);
    bus_read(d, oe);
    chk("R12 high byte from captured sample", {3'b0, d}, 16'h000A);
    bus_read(d, oe);
    chk("R12 next low byte from new sample", {3'b0, d}, 16'h0001);

    // R3 and R4: rising-edge strap
    do_reset(1'b0);
    chk("R1 cfg after second reset", {8'h0, cfg_q}, 16'h0010);
    split_write(8'h98, 8'h84);
    chk("R3 rising edge data", {8'h0, cfg_q}, 16'h0084);
    wr_edge_sel = 1'b1; wait_n(3);
    split_write(8'h98, 8'h8C);
    chk("R4 strap change ignored", {8'h0, cfg_q}, 16'h008C);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule